// File: doc/BRIEF.md
# Clock Mode and Wake-Source Controller

This block sets the machine-cycle rate of a small microcontroller core and picks the source that clocks the core after a stop. It works in one fabric clock domain. The crystal and the fast-start ring reference arrive as single-cycle tick strobes (`xtal_tick_i`, `ring_tick_i`) and are sampled on `clk`. A three-bit mode word `{mult, div[1:0]}` sets the rate. Divide-by-one emits one machine-cycle enable per source tick. Divide-by-1024 emits one enable per 1024 source ticks. The two multiply settings are reported on a rate code and otherwise behave as divide-by-one.

Software raises `stop_req_i` to halt the core. A `wake_i` pulse ends the stop, and the crystal is then counted for 2^STAB_W ticks before it is trusted. The ring-select input is sampled at the wake and decides what happens during that count. With it clear, the core stays halted for the whole count. With it set, the core runs at once from ring ticks with the divider pinned to divide-by-one, and it moves back to the crystal when the count ends. The watchdog tick is always a copy of the crystal strobe.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode word is 010 (divide-by-one), `rate_code_o` is 00, `cpu_run_o` is 1 and `ring_active_o` is 0.
- R2: In divide-by-one and both multiply modes, `mc_en_o` is high one cycle after each source tick while running. `rate_code_o` encodes the mode as follows: 100 gives 10 (x4), 000 gives 01 (x2), x10 gives 00 (divide-by-one) and x11 gives 11 (divide-by-1024).
- R3: In mode x11, `mc_en_o` pulses once on every 1024th source tick. Any accepted mode write restarts that count from zero.
- R4: A mode write whose low two bits are 01 is ignored, and the previous mode and rate code are kept.
- R5: After `stop_req_i` the core is halted: `cpu_run_o` is 0 and `mc_en_o` stays low until `wake_i`.
- R6: On a wake with ring-select at 0, `cpu_run_o` stays 0 until 2^STAB_W crystal ticks have been counted, and the core then runs from the crystal.
- R7: On a wake with ring-select at 1, `ring_active_o` and `cpu_run_o` go high at once and `mc_en_o` follows ring ticks. After 2^STAB_W crystal ticks the source returns to the crystal and `ring_active_o` drops to 0.
- R8: While on the ring source, the divide bits are forced to 10 and mode writes are ignored. The forced value remains after the handover.
- R9: `wdt_tick_o` follows `xtal_tick_i` one cycle later in every state and never follows ring ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 3 | Mode word {mult, div1, div0} |
| ring_sel_i | input | 1 | Run from the ring clock after wake |
| stop_req_i | input | 1 | Enter stop |
| wake_i | input | 1 | Stop-exit wake pulse |
| xtal_tick_i | input | 1 | Crystal reference tick strobe |
| ring_tick_i | input | 1 | Ring reference tick strobe |
| mc_en_o | output | 1 | Machine-cycle enable |
| cpu_run_o | output | 1 | Core run enable |
| ring_active_o | output | 1 | Ring clock is the system source |
| wdt_tick_o | output | 1 | Watchdog tick, crystal only |
| rate_code_o | output | 2 | Rate code of current mode |

## Verification
The bench drives crystal and ring ticks with different, irregular patterns during a ring-sourced wake. A design that took enables or watchdog ticks from the wrong strobe, or that handed over at the wrong count, fails there. Writing the reserved code, and writing during the ring phase, catches a mode register that accepts illegal or locked writes, because the rate code or the enable spacing would then move. The bench runs divide-by-1024 across several full periods and rewrites the mode partway through. An off-by-one terminal count or a counter that does not restart shows up as a misplaced pulse.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAIT = 2'd2,
    ST_RING = 2'd3
  } src_state_t;

  function automatic logic [1:0] rate_enc(input logic [2:0] m);
    if (m[1:0] == 2'b11)      rate_enc = 2'b11;
    else if (m == 3'b100)     rate_enc = 2'b10;
    else if (m == 3'b000)     rate_enc = 2'b01;
    else                      rate_enc = 2'b00;
  endfunction
endpackage

// File: rtl/cm_mode_reg.sv
module cm_mode_reg
  import clk_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  input  logic       force_i,
  input  logic       lock_i,
  output logic [2:0] mode_o,
  output logic [1:0] rate_o,
  output logic       restart_o
);
  logic [2:0] mode_q, mode_d;
  logic [1:0] rate_q;
  logic       accept;

  always_comb begin
    accept = wr_i && !lock_i && !force_i && (wdata_i[1:0] != 2'b01);
    mode_d = mode_q;
    if (force_i)     mode_d = {mode_q[2], 2'b10};
    else if (accept) mode_d = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 3'b010;
      rate_q <= 2'b00;
    end else begin
      mode_q <= mode_d;
      rate_q <= rate_enc(mode_d);
    end
  end

  assign mode_o    = mode_q;
  assign rate_o    = rate_q;
  assign restart_o = accept || force_i;

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_i && wdata_i[1:0] == 2'b01 && !force_i) |=> $stable(mode_q)); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (lock_i && !force_i) |=> $stable(mode_q)); // R8
endmodule

// File: rtl/cm_mc_div.sv
module cm_mc_div #(
  parameter int DIV_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic tick_i,
  input  logic slow_i,
  input  logic restart_i,
  output logic mc_en_o
);
  localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

  logic [DIV_W-1:0] cnt_q;
  logic             mc_q;
  logic             step;

  assign step = active_i && tick_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mc_q  <= 1'b0;
    end else begin
      mc_q <= step && (!slow_i || cnt_q == CNT_MAX);
      if (restart_i)
        cnt_q <= '0;
      else if (step && slow_i)
        cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
    end
  end

  assign mc_en_o = mc_q;

  AST_SLOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && slow_i && !restart_i && cnt_q == CNT_MAX) |=> (cnt_q == '0 && mc_q)); // R3
endmodule

// File: rtl/cm_src_ctrl.sv
module cm_src_ctrl
  import clk_mode_pkg::*;
#(
  parameter int STAB_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req_i,
  input  logic       wake_i,
  input  logic       ring_sel_i,
  input  logic       xtal_tick_i,
  output src_state_t st_o,
  output logic       force_div1_o,
  output logic       cpu_run_o,
  output logic       ring_active_o
);
  localparam logic [STAB_W-1:0] STAB_MAX = {STAB_W{1'b1}};

  src_state_t        st_q, st_d;
  logic [STAB_W-1:0] stab_q;
  logic              settling, stab_done;
  logic              run_q, ring_q;

  assign settling  = (st_q == ST_WAIT) || (st_q == ST_RING);
  assign stab_done = settling && xtal_tick_i && (stab_q == STAB_MAX);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (stop_req_i) st_d = ST_STOP;
      ST_STOP: if (wake_i)     st_d = ring_sel_i ? ST_RING : ST_WAIT;
      default: if (stab_done)  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      stab_q <= '0;
      run_q  <= 1'b1;
      ring_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      run_q  <= (st_q == ST_RUN) || (st_q == ST_RING);
      ring_q <= (st_q == ST_RING);
      if (!settling || stab_done) stab_q <= '0;
      else if (xtal_tick_i)       stab_q <= stab_q + 1'b1;
    end
  end

  assign st_o          = st_q;
  assign force_div1_o  = (st_q == ST_STOP) && wake_i && ring_sel_i;
  assign cpu_run_o     = run_q;
  assign ring_active_o = ring_q;

  AST_WAIT_HALTED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |=> !cpu_run_o); // R6
  AST_RING_RUNS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RING) |=> (cpu_run_o && ring_active_o)); // R7
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int STAB_W = 16,
  parameter int DIV_W  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr_i,
  input  logic [2:0] mode_wdata_i,
  input  logic       ring_sel_i,
  input  logic       stop_req_i,
  input  logic       wake_i,
  input  logic       xtal_tick_i,
  input  logic       ring_tick_i,
  output logic       mc_en_o,
  output logic       cpu_run_o,
  output logic       ring_active_o,
  output logic       wdt_tick_o,
  output logic [1:0] rate_code_o
);
  src_state_t st;
  logic       force_div1, restart;
  logic [2:0] mode;
  logic       src_tick, active, wdt_q;

  cm_src_ctrl #(.STAB_W(STAB_W)) u_src (
    .clk(clk), .rst(rst),
    .stop_req_i(stop_req_i), .wake_i(wake_i), .ring_sel_i(ring_sel_i),
    .xtal_tick_i(xtal_tick_i),
    .st_o(st), .force_div1_o(force_div1),
    .cpu_run_o(cpu_run_o), .ring_active_o(ring_active_o)
  );

  cm_mode_reg u_mode (
    .clk(clk), .rst(rst),
    .wr_i(mode_wr_i), .wdata_i(mode_wdata_i),
    .force_i(force_div1), .lock_i(st == ST_RING),
    .mode_o(mode), .rate_o(rate_code_o), .restart_o(restart)
  );

  assign src_tick = (st == ST_RING) ? ring_tick_i : xtal_tick_i;
  assign active   = (st == ST_RUN) || (st == ST_RING);

  cm_mc_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst),
    .active_i(active), .tick_i(src_tick),
    .slow_i(mode[1:0] == 2'b11), .restart_i(restart),
    .mc_en_o(mc_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_q <= 1'b0;
    else     wdt_q <= xtal_tick_i;
  end
  assign wdt_tick_o = wdt_q;

  AST_RING_DIV1: assert property (@(posedge clk) disable iff (rst)
    ring_active_o |-> (mode[1:0] == 2'b10)); // R8
  AST_HALT_NO_MC: assert property (@(posedge clk) disable iff (rst)
    mc_en_o |-> cpu_run_o); // R5
  AST_NO_RSVD_MODE: assert property (@(posedge clk) disable iff (rst)
    mode[1:0] != 2'b01); // R4
endmodule

// File: tb/clk_mode_ctrl_tb.sv
module clk_mode_ctrl_tb;
  localparam int STAB_W = 4;
  localparam int DIV_W  = 10;
  localparam int STAB_N = 1 << STAB_W;
  localparam int DIV_MAX = (1 << DIV_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 0, ring_sel = 0, stop_req = 0, wake = 0, xt = 0, rt = 0;
  logic [2:0] mode_wdata = 3'b000;
  logic mc_en, cpu_run, ring_active, wdt_tick;
  logic [1:0] rate_code;

  always #2.5 clk = ~clk;

  clk_mode_ctrl #(.STAB_W(STAB_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst),
    .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata), .ring_sel_i(ring_sel),
    .stop_req_i(stop_req), .wake_i(wake),
    .xtal_tick_i(xt), .ring_tick_i(rt),
    .mc_en_o(mc_en), .cpu_run_o(cpu_run), .ring_active_o(ring_active),
    .wdt_tick_o(wdt_tick), .rate_code_o(rate_code)
  );

  typedef struct {
    logic [5:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];

  int n_tests = 0, n_fail = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int         m_st = 0;   // 0 run, 1 stop, 2 wait, 3 ring
  logic [2:0] m_mode = 3'b010;
  int         m_cnt = 0;
  int         m_stab = 0;

  function automatic logic [1:0] ref_rate(input logic [2:0] m);
    case (m)
      3'b100: return 2'b10;
      3'b000: return 2'b01;
      3'b011, 3'b111: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic step(input logic wr, input logic [2:0] wd, input logic sreq,
                      input logic wk, input logic rs, input logic x, input logic r,
                      input string tag);
    logic tick, act, slow, frc, acc, e_mc;
    exp_t e;
    @(negedge clk);
    mode_wr = wr; mode_wdata = wd; stop_req = sreq; wake = wk;
    ring_sel = rs; xt = x; rt = r;
    tick = (m_st == 3) ? r : x;
    act  = (m_st == 0) || (m_st == 3);
    slow = (m_mode[1:0] == 2'b11);
    e_mc = act && tick && (!slow || m_cnt == DIV_MAX);
    frc  = (m_st == 1) && wk && rs;
    acc  = wr && (m_st != 3) && !frc && (wd[1:0] != 2'b01);
    if (frc) m_mode = {m_mode[2], 2'b10};
    else if (acc) m_mode = wd;
    if (frc || acc) m_cnt = 0;
    else if (act && tick && slow) m_cnt = (m_cnt == DIV_MAX) ? 0 : m_cnt + 1;
    e.v = {e_mc, act, (m_st == 3), x, ref_rate(m_mode)};
    e.tag = tag;
    case (m_st)
      0: if (sreq) m_st = 1;
      1: if (wk) begin m_st = rs ? 3 : 2; m_stab = 0; end
      default: if (x) begin
        if (m_stab == STAB_N - 1) begin m_st = 0; m_stab = 0; end
        else m_stab++;
      end
    endcase
    q.push_back(e);
  endtask

  // monitor: compares outputs just after each edge
  always @(posedge clk) begin
    exp_t e;
    logic [5:0] act_v;
    #1;
    if (!rst && q.size() > 0) begin
      e = q.pop_front();
      act_v = {mc_en, cpu_run, ring_active, wdt_tick, rate_code};
      n_tests++;
      if (act_v !== e.v) begin
        n_fail++;
        $display("FAIL %s: {mc,run,ring,wdt,rate} actual=%b expected=%b at cycle %0d",
                 e.tag, act_v, e.v, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    n_tests++;
    if (!(cpu_run === 1 && ring_active === 0 && rate_code === 2'b00 && mc_en === 0)) begin
      n_fail++;
      $display("FAIL R1: run=%b ring=%b rate=%b mc=%b expected 1 0 00 0",
               cpu_run, ring_active, rate_code, mc_en);
    end
    // R1 / R2: divide-by-one following an irregular crystal pattern
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, (i % 3) != 1, 1, "R1_R2_div1");
    // R2: multiply modes and rate codes
    step(1, 3'b000, 0, 0, 0, 1, 0, "R2_x2");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, i[0], 0, "R2_x2");
    step(1, 3'b100, 0, 0, 0, 0, 0, "R2_x4");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, !i[1], 0, "R2_x4");
    step(1, 3'b110, 0, 0, 0, 1, 0, "R2_div1_alt");
    // R4: reserved codes ignored
    step(1, 3'b001, 0, 0, 0, 1, 0, "R4_rsvd");
    step(1, 3'b101, 0, 0, 0, 1, 0, "R4_rsvd");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 0, "R4_rsvd");
    // R3: divide-by-1024, restart on rewrite
    step(1, 3'b011, 0, 0, 0, 1, 0, "R3_div1024");
    for (int i = 0; i < 2200; i++) step(0, 0, 0, 0, 0, (i % 7) != 3, 0, "R3_div1024");
    step(1, 3'b111, 0, 0, 0, 1, 0, "R3_restart");
    for (int i = 0; i < 1100; i++) step(0, 0, 0, 0, 0, 1, 0, "R3_restart");
    // R5 / R6: stop, wake without ring
    step(1, 3'b010, 0, 0, 0, 1, 0, "R5_setup");
    step(0, 0, 1, 0, 0, 1, 1, "R5_stop");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1, 1, "R5_stop");
    step(0, 0, 0, 1, 0, 1, 1, "R6_wake");
    for (int i = 0; i < 3 * STAB_N; i++) step(0, 0, 0, 0, 0, i[0], 1, "R6_settle");
    // R7 / R8 / R9: wake on ring
    step(1, 3'b011, 0, 0, 0, 1, 0, "R8_setup");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, 0, "R8_setup");
    step(0, 0, 1, 0, 0, 0, 0, "R7_stop");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 1, "R7_stop");
    step(0, 0, 0, 1, 1, 0, 1, "R7_wake");
    for (int i = 0; i < 4 * STAB_N; i++)
      step((i % 5) == 2, 3'b011, 0, 0, 0, (i % 3) == 0, (i % 4) != 2, "R7_R8_R9_ring");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, i[0], !i[0], "R8_R9_after");
    step(0, 0, 0, 0, 0, 0, 0, "drain");
    @(posedge clk); #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule